// File: doc/BRIEF.md
# Overflow-Flagged 8-bit Timer Counter

This block is an up-counter with an overflow flag. It is meant to sit behind a small CPU register port. A one-cycle timer enable, which is produced elsewhere, advances the count by one. When the count rolls past its top value back to zero, the block raises a sticky overflow flag. That flag acts as a ninth count bit that only hardware can set.

Software can read and write the count at any time, and a write takes precedence over counting. Software clears the flag by writing a one to it. The interrupt controller clears it with an acknowledge pulse. An interrupt request is raised while three things are true together: the flag is set, a local enable bit is set, and a global enable input is high. Clock-source selection and prescaling happen upstream of the block.

Top module: `ovf_timer8`

## Requirements
- R1: After reset the count, the overflow flag and the interrupt enable bit are all zero, and `intReq` is low.
- R2: In a cycle where `tickEn` is high and no count write occurs, the count rises by exactly one at that clock edge.
- R3: A counted step from 0xFF gives 0x00, and the overflow flag (status register, address 1, bit 0) is set after that same edge.
- R4: A CPU write to the count register (address 0) stores the written value. It overrides a simultaneous `tickEn`: there is no increment, and the flag is not set, even when the count was 0xFF.
- R5: With `tickEn` low the count holds its value, and reads and writes of the count still work.
- R6: Writing a one to address 1 bit 0 clears the flag. Writing a zero there leaves the flag unchanged.
- R7: A one-cycle `intAck` pulse clears the flag.
- R8: When an overflow and a clear request (a write-one-to-clear or `intAck`) happen in the same cycle, the flag ends up set.
- R9: `intReq` is high exactly when the flag, the enable bit and `globalIntEn` are all one.
- R10: The interrupt enable bit is address 2 bit 0. A write stores it, and a read returns it. All other read bits are zero.
- R11: Address 3 reads as zero. Writes to address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timer clock enable, one cycle per count |
| regAddr | input | 2 | Register select: 0 count, 1 status, 2 control, 3 unused |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr`, combinational |
| intAck | input | 1 | Interrupt acknowledge, clears the flag |
| globalIntEn | input | 1 | Global interrupt enable |
| intReq | output | 1 | Overflow interrupt request |

## Verification
Every register updates on the edge that samples its stimulus. A write, tick or acknowledge presented before an edge is therefore visible on `regRdData` one cycle later. `intReq` follows the flag and the enable bit in that same cycle, and it follows `globalIntEn` with no delay at all. The bench drives inputs on falling edges and removes them on the next falling edge. It reads back only at falling edges, after the rising edge that should have made the change. The overflow check steps the count up to 0xFF, samples the flag, and confirms it is still clear. It then samples again one tick later, so an early or late flag shows up in the wrong sample.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;

  typedef enum logic [1:0] {
    ADDR_COUNT  = 2'd0,
    ADDR_STATUS = 2'd1,
    ADDR_CTRL   = 2'd2,
    ADDR_SPARE  = 2'd3
  } regAddrE;

  typedef struct packed {
    logic loadCount;
    logic stepCount;
    logic clearFlag;
    logic writeEnable;
  } ctrlStrobeT;

endpackage

// File: rtl/ovf_timer_dp.sv
module ovf_timer_dp
  import ovf_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobes,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countVal,
  output logic             wrapEvent
);

  localparam logic [CNT_W-1:0] CountMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] countQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobes.loadCount) begin
      countQ <= wrData;
    end else if (strobes.stepCount) begin
      countQ <= countQ + CNT_W'(1);
    end
  end

  assign wrapEvent = strobes.stepCount && (countQ == CountMax);
  assign countVal  = countQ;

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepCount && !strobes.loadCount) |=> countQ == $past(countQ) + CNT_W'(1));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.stepCount && !strobes.loadCount) |=> $stable(countQ));

  p_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCount |=> countQ == $past(wrData));

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvent |=> countQ == '0);

endmodule

// File: rtl/ovf_timer_ctrl.sv
module ovf_timer_ctrl
  import ovf_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  regAddrE          regAddr,
  input  logic             regWrEn,
  input  logic             wrBit0,
  input  logic             tickEn,
  input  logic             intAck,
  input  logic             globalIntEn,
  input  logic             wrapEvent,
  input  logic [CNT_W-1:0] countVal,
  output ctrlStrobeT       strobes,
  output logic [CNT_W-1:0] rdData,
  output logic             intReq
);

  logic ovfFlag;
  logic irqEnable;

  always_comb begin
    strobes             = '0;
    strobes.loadCount   = regWrEn && (regAddr == ADDR_COUNT);
    strobes.stepCount   = tickEn && !strobes.loadCount;
    strobes.clearFlag   = regWrEn && (regAddr == ADDR_STATUS) && wrBit0;
    strobes.writeEnable = regWrEn && (regAddr == ADDR_CTRL);
  end

  // Setting on overflow wins over any clear request in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
    end else if (wrapEvent) begin
      ovfFlag <= 1'b1;
    end else if (strobes.clearFlag || intAck) begin
      ovfFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEnable <= 1'b0;
    end else if (strobes.writeEnable) begin
      irqEnable <= wrBit0;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (regAddr)
      ADDR_COUNT:  rdData = countVal;
      ADDR_STATUS: rdData[0] = ovfFlag;
      ADDR_CTRL:   rdData[0] = irqEnable;
      ADDR_SPARE:  rdData = '0;
    endcase
  end

  assign intReq = ovfFlag && irqEnable && globalIntEn;

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvent |=> ovfFlag);

  p_w1c_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearFlag && !wrapEvent) |=> !ovfFlag);

  p_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !wrapEvent) |=> !ovfFlag);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !intAck && !strobes.clearFlag) |=> ovfFlag);

  p_load_blocks_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCount |-> !strobes.stepCount);

endmodule

// File: rtl/ovf_timer8.sv
module ovf_timer8
  import ovf_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData,
  input  logic             intAck,
  input  logic             globalIntEn,
  output logic             intReq
);

  ctrlStrobeT       strobes;
  logic [CNT_W-1:0] countVal;
  logic             wrapEvent;

  ovf_timer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regAddr     (regAddrE'(regAddr)),
    .regWrEn     (regWrEn),
    .wrBit0      (regWrData[0]),
    .tickEn      (tickEn),
    .intAck      (intAck),
    .globalIntEn (globalIntEn),
    .wrapEvent   (wrapEvent),
    .countVal    (countVal),
    .strobes     (strobes),
    .rdData      (regRdData),
    .intReq      (intReq)
  );

  ovf_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (regWrData),
    .countVal  (countVal),
    .wrapEvent (wrapEvent)
  );

endmodule

// File: tb/sim_ovf_timer8.sv
`timescale 1ns/1ps
module sim_ovf_timer8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       intAck = 1'b0;
  logic       globalIntEn = 1'b0;
  logic       intReq;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  ovf_timer8 u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .intAck(intAck), .globalIntEn(globalIntEn), .intReq(intReq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  // Drive one cycle of stimulus starting at a falling edge.
  task automatic cycle(input logic wr, input logic [1:0] a, input logic [7:0] d,
                       input logic tk, input logic ack);
    @(negedge clk);
    regWrEn = wr; regAddr = a; regWrData = d; tickEn = tk; intAck = ack;
    @(negedge clk);
    regWrEn = 1'b0; tickEn = 1'b0; intAck = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] d;
    readReg(a, d);
    check(req, d, exp);
  endtask

  task automatic testReset();
    expectReg("R1 count", 2'd0, 8'h00);
    expectReg("R1 flag", 2'd1, 8'h00);
    expectReg("R1 enable", 2'd2, 8'h00);
    check("R1 intReq", {7'd0, intReq}, 8'h00);
  endtask

  task automatic testCountHold();
    ticks(5);
    expectReg("R2 count after 5 ticks", 2'd0, 8'h05);
    repeat (4) @(negedge clk);
    expectReg("R5 hold without tick", 2'd0, 8'h05);
    cycle(1'b1, 2'd0, 8'h42, 1'b0, 1'b0);
    expectReg("R5 write without tick", 2'd0, 8'h42);
  endtask

  task automatic testWrap();
    cycle(1'b1, 2'd0, 8'hFD, 1'b0, 1'b0);
    ticks(2);
    expectReg("R3 count at FF", 2'd0, 8'hFF);
    expectReg("R3 flag clear before wrap", 2'd1, 8'h00);
    ticks(1);
    expectReg("R3 count wraps to 00", 2'd0, 8'h00);
    expectReg("R3 flag set on wrap", 2'd1, 8'h01);
  endtask

  task automatic testClear();
    cycle(1'b1, 2'd1, 8'hFE, 1'b0, 1'b0);
    expectReg("R6 write zero keeps flag", 2'd1, 8'h01);
    cycle(1'b1, 2'd1, 8'h01, 1'b0, 1'b0);
    expectReg("R6 write one clears flag", 2'd1, 8'h00);
    cycle(1'b1, 2'd0, 8'hFF, 1'b0, 1'b0);
    ticks(1);
    expectReg("R3 flag set again", 2'd1, 8'h01);
    cycle(1'b0, 2'd1, 8'h00, 1'b0, 1'b1);
    expectReg("R7 ack clears flag", 2'd1, 8'h00);
  endtask

  task automatic testPriority();
    cycle(1'b1, 2'd0, 8'h10, 1'b1, 1'b0);
    expectReg("R4 write beats tick", 2'd0, 8'h10);
    cycle(1'b1, 2'd0, 8'hFF, 1'b0, 1'b0);
    cycle(1'b1, 2'd0, 8'h20, 1'b1, 1'b0);
    expectReg("R4 write at FF with tick", 2'd0, 8'h20);
    expectReg("R4 no flag from overridden wrap", 2'd1, 8'h00);
  endtask

  task automatic testSetWins();
    cycle(1'b1, 2'd0, 8'hFF, 1'b0, 1'b0);
    cycle(1'b1, 2'd1, 8'h01, 1'b1, 1'b0);
    expectReg("R8 wrap beats write-one-clear", 2'd1, 8'h01);
    expectReg("R8 count wrapped", 2'd0, 8'h00);
    cycle(1'b1, 2'd0, 8'hFF, 1'b0, 1'b0);
    cycle(1'b0, 2'd0, 8'h00, 1'b1, 1'b1);
    expectReg("R8 wrap beats ack", 2'd1, 8'h01);
  endtask

  task automatic testIrq();
    globalIntEn = 1'b1;
    #0.5;
    check("R9 no irq with enable low", {7'd0, intReq}, 8'h00);
    cycle(1'b1, 2'd2, 8'hFF, 1'b0, 1'b0);
    expectReg("R10 enable readback", 2'd2, 8'h01);
    check("R9 irq with all three", {7'd0, intReq}, 8'h01);
    globalIntEn = 1'b0;
    #0.5;
    check("R9 no irq with global low", {7'd0, intReq}, 8'h00);
    globalIntEn = 1'b1;
    cycle(1'b0, 2'd0, 8'h00, 1'b0, 1'b1);
    check("R9 no irq after ack", {7'd0, intReq}, 8'h00);
    cycle(1'b1, 2'd2, 8'h00, 1'b0, 1'b0);
    expectReg("R10 enable cleared", 2'd2, 8'h00);
    globalIntEn = 1'b0;
  endtask

  task automatic testSpare();
    cycle(1'b1, 2'd0, 8'h33, 1'b0, 1'b0);
    cycle(1'b1, 2'd3, 8'hFF, 1'b0, 1'b0);
    expectReg("R11 spare reads zero", 2'd3, 8'h00);
    expectReg("R11 count untouched", 2'd0, 8'h33);
    expectReg("R11 flag untouched", 2'd1, 8'h00);
    expectReg("R11 enable untouched", 2'd2, 8'h00);
  endtask

  initial begin
    #100000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCountHold();
    testWrap();
    testClear();
    testPriority();
    testSetWins();
    testIrq();
    testSpare();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule